// File: doc/BRIEF.md
# Fall-Through FIFO with Shift Handshake

This block is a 64-word by 4-bit first-in first-out buffer whose oldest word moves to the output stage on its own, with no read request. A producer offers a word on `data_in` and raises `shift_in`. A consumer sees `out_rdy` high with the word on `data_out`, and takes it by pulsing `shift_out` high then low. The producer paces itself on `in_rdy`, and the consumer paces itself on `out_rdy`.

Both strobes are plain levels sampled on the single system clock. A word is accepted once per high period of `shift_in`. It is removed on the high-to-low transition of `shift_out`, seen on two consecutive clock samples. Two corner cases proceed without further action from either side. When the buffer is full and `shift_in` is held high, removing a word lets the waiting input word in, and `in_rdy` shows a one-clock pulse. When the buffer is empty and `shift_out` is held high, a newly written word still falls through, and `out_rdy` shows a one-clock pulse. The master reset is active low and synchronous. `DEPTH` must be a power of two.

Top module: `ft_fifo`

## Requirements
- R1: While `rst_n` is sampled low, the buffer is emptied and, from the next clock, `in_rdy` is 1, `out_rdy` is 0 and `data_out` is all zeros.
- R2: A word on `data_in` is stored at a clock edge where `shift_in` is sampled high, `in_rdy` is 1, the buffer is not full, and no word has yet been stored in the current high period of `shift_in`. After a store, `in_rdy` stays 0 until `shift_in` is sampled low.
- R3: The buffer holds up to 64 words and delivers them in write order, with `data_out` bit-for-bit equal to the `data_in` value that was stored.
- R4: While 64 words are held, `in_rdy` is 0, and pulses on `shift_in` store nothing.
- R5: A word presented with its data on `data_out` is removed when `shift_out` is sampled high and then low on the next edge. `out_rdy` is 0 from the clock after `shift_out` is sampled high.
- R6: While the buffer is empty, `out_rdy` is 0, and pulses on `shift_out` change neither `out_rdy` nor `data_out`.
- R7: A word written into an empty buffer appears on `data_out`, with `out_rdy` high, at the first clock edge where `shift_in` is sampled low after the write. The latency is one clock.
- R8: After its word is removed, `data_out` keeps that word until a new word falls through or reset is asserted.
- R9: With `shift_out` held high and the buffer empty, a written word still falls through, and `out_rdy` is high for exactly one clock.
- R10: With the buffer full and `shift_in` held high, the removal of a word raises `in_rdy` for exactly one clock. The waiting input word is then stored, and it is delivered after the 63 words ahead of it.
- R11: If `shift_in` is high at the first clock after reset release, that word is stored and `in_rdy` stays 0 until `shift_in` is sampled low. If `shift_in` is low at release, nothing is stored and `in_rdy` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples both strobes |
| rst_n | input | 1 | Synchronous master reset, active low |
| shift_in | input | 1 | Producer strobe; a high period offers one word |
| data_in | input | WIDTH | Word offered by the producer |
| in_rdy | output | 1 | Buffer can accept the offered word |
| shift_out | input | 1 | Consumer strobe; a high-to-low transition removes the presented word |
| out_rdy | output | 1 | A valid word is presented on data_out |
| data_out | output | WIDTH | Oldest stored word, or the last word delivered |

## Verification
Most faults in this block show up at the ports within a few clocks. A pointer or count off by one either repeats or drops a word in the delivered sequence, or makes `in_rdy` fall at 63 or 65 words instead of 64. A presentation flag that is out of step makes `out_rdy` stay high while `shift_out` is high, or makes `data_out` change with no rise of `out_rdy`, in the very next clock. Missed bookkeeping of the `shift_in` high period shows up as a word stored twice, which is visible in the drained order and counted against the 64-word limit. The two auto-pass cases and the reset-release capture are each driven on purpose, because a fault in them never appears under ordinary handshakes.

// File: rtl/ft_fifo_pkg.sv
package ft_fifo_pkg;

    localparam int FT_DEPTH = 64;
    localparam int FT_WIDTH = 4;

    // one-clock actions decided by the control stage
    typedef struct packed {
        logic push;   // store data_in at the tail
        logic pop;    // retire the presented head word
        logic load;   // copy the head word into the output stage
    } ft_cmd_t;

    // registered handshake state
    typedef struct packed {
        logic ir;     // input ready flag
        logic orr;    // output ready flag
        logic used;   // a word was taken in this shift_in high period
        logic pres;   // the head word is sitting in the output stage
    } ft_flags_t;

    localparam ft_flags_t FT_FLAGS_RST = '{ir: 1'b1, orr: 1'b0, used: 1'b0, pres: 1'b0};

    // full after this clock, given the current state and the actions taken
    function automatic logic ft_full_next(input logic full, input logic nearly,
                                          input ft_cmd_t cmd);
        return (full & ~cmd.pop) | (nearly & cmd.push & ~cmd.pop);
    endfunction

endpackage

// File: rtl/ft_strobe_edge.sv
module ft_strobe_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    output logic fell
);
    logic strobe_q;

    always_ff @(posedge clk) begin
        if (!rst_n) strobe_q <= 1'b0;
        else        strobe_q <= strobe;
    end

    assign fell = strobe_q & ~strobe;
endmodule

// File: rtl/ft_store.sv
module ft_store #(
    parameter int DEPTH = 64,
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] head,
    output logic             empty,
    output logic             full,
    output logic             nearly,
    output logic             multi
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PW-1:0]    wr_ptr, rd_ptr, fill;

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr[AW-1:0]] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (push) wr_ptr <= wr_ptr + PW'(1);
            if (pop)  rd_ptr <= rd_ptr + PW'(1);
        end
    end

    assign fill   = wr_ptr - rd_ptr;
    assign head   = mem[rd_ptr[AW-1:0]];
    assign empty  = (fill == '0);
    assign full   = (fill == PW'(DEPTH));
    assign nearly = (fill == PW'(DEPTH - 1));
    assign multi  = (fill > PW'(1));
endmodule

// File: rtl/ft_ctrl.sv
module ft_ctrl
    import ft_fifo_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             si,
    input  logic             so,
    input  logic             so_fall,
    input  logic             empty,
    input  logic             full,
    input  logic             nearly,
    input  logic             multi,
    input  logic [WIDTH-1:0] head,
    output ft_cmd_t          cmd,
    output logic             in_rdy,
    output logic             out_rdy,
    output logic [WIDTH-1:0] data_out
);
    ft_flags_t        cur, nxt;
    logic [WIDTH-1:0] dout_q;
    logic             full_n;

    always_comb begin
        cmd.push = si & ~cur.used & ~full & cur.ir;
        cmd.pop  = so_fall & cur.pres;
        // the only stored word waits while its own shift_in period is still open
        cmd.load = ~cur.pres & (multi | (~empty & ~si));

        full_n   = ft_full_next(full, nearly, cmd);

        nxt.used = si & (cur.used | cmd.push);
        nxt.ir   = ~full_n & ~(si & nxt.used);
        nxt.pres = cmd.load | (cur.pres & ~cmd.pop);
        nxt.orr  = cmd.load | (nxt.pres & ~so);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur    <= FT_FLAGS_RST;
            dout_q <= '0;
        end else begin
            cur <= nxt;
            if (cmd.load) dout_q <= head;
        end
    end

    assign in_rdy   = cur.ir;
    assign out_rdy  = cur.orr;
    assign data_out = dout_q;
endmodule

// File: rtl/ft_fifo.sv
module ft_fifo
    import ft_fifo_pkg::*;
#(
    parameter int DEPTH = FT_DEPTH,
    parameter int WIDTH = FT_WIDTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_in,
    input  logic [WIDTH-1:0] data_in,
    output logic             in_rdy,
    input  logic             shift_out,
    output logic             out_rdy,
    output logic [WIDTH-1:0] data_out
);
    ft_cmd_t          cmd;
    logic             so_fall;
    logic             empty, full, nearly, multi;
    logic             push, pop;
    logic [WIDTH-1:0] head;

    ft_strobe_edge u_so_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe (shift_out),
        .fell   (so_fall)
    );

    ft_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .push   (push),
        .pop    (pop),
        .wdata  (data_in),
        .head   (head),
        .empty  (empty),
        .full   (full),
        .nearly (nearly),
        .multi  (multi)
    );

    ft_ctrl #(.WIDTH(WIDTH)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .si       (shift_in),
        .so       (shift_out),
        .so_fall  (so_fall),
        .empty    (empty),
        .full     (full),
        .nearly   (nearly),
        .multi    (multi),
        .head     (head),
        .cmd      (cmd),
        .in_rdy   (in_rdy),
        .out_rdy  (out_rdy),
        .data_out (data_out)
    );

    assign push = cmd.push;
    assign pop  = cmd.pop;
endmodule

// File: rtl/ft_fifo_chk.sv
module ft_fifo_chk #(
    parameter int WIDTH = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             shift_out,
    input logic             in_rdy,
    input logic             out_rdy,
    input logic [WIDTH-1:0] data_out,
    input logic             full,
    input logic             empty,
    input logic             push,
    input logic             pop
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (in_rdy && !out_rdy && data_out == '0));

    // R4
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> (!push && !in_rdy));

    // R6
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> (!pop && !out_rdy));

    // R2
    ir_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> !in_rdy);

    // R5
    or_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_out && out_rdy) |=> !out_rdy);

    // R8
    dout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(out_rdy) |-> $stable(data_out));
endmodule

bind ft_fifo ft_fifo_chk #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .shift_out (shift_out),
    .in_rdy    (in_rdy),
    .out_rdy   (out_rdy),
    .data_out  (data_out),
    .full      (full),
    .empty     (empty),
    .push      (push),
    .pop       (pop)
);

// File: tb/sim_ft_fifo.sv
module sim_ft_fifo;
    localparam int DEPTH = 64;
    localparam int WIDTH = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             si = 1'b0;
    logic             so = 1'b0;
    logic [WIDTH-1:0] din = '0;
    logic             in_rdy, out_rdy;
    logic [WIDTH-1:0] dout;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // behavioural reference state
    logic [WIDTH-1:0] m_q[$];
    bit               m_used, m_pres, m_ir, m_or, m_soq;
    logic [WIDTH-1:0] m_dout;

    always #5 clk = ~clk;

    ft_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u0 (
        .clk(clk), .rst_n(rst_n), .shift_in(si), .data_in(din), .in_rdy(in_rdy),
        .shift_out(so), .out_rdy(out_rdy), .data_out(dout)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_edge();
        bit push, pop, load, so_fall;
        int n;
        if (!rst_n) begin
            m_q.delete();
            m_used = 0; m_pres = 0; m_ir = 1; m_or = 0; m_soq = 0; m_dout = '0;
            return;
        end
        n       = m_q.size();
        so_fall = m_soq && !so;
        push    = si && !m_used && (n < DEPTH) && m_ir;
        pop     = so_fall && m_pres;
        load    = !m_pres && (n >= 2 || (n == 1 && !si));
        if (load) m_dout = m_q[0];
        m_pres = load || (m_pres && !pop);
        if (pop)  void'(m_q.pop_front());
        if (push) m_q.push_back(din);
        m_used = si && (m_used || push);
        m_ir   = (m_q.size() != DEPTH) && !(si && m_used);
        m_or   = load || (m_pres && !so);
        m_soq  = so;
    endtask

    // one clock: drive, clock, update model, compare away from the edge
    task automatic step(input bit s_in, input logic [WIDTH-1:0] d, input bit s_out);
        si = s_in; din = d; so = s_out;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        chk("R2 model in_rdy", int'(in_rdy), int'(m_ir));
        chk("R5 model out_rdy", int'(out_rdy), int'(m_or));
        chk("R3 model data_out", int'(dout), int'(m_dout));
    endtask

    task automatic put(input logic [WIDTH-1:0] d);
        step(1'b1, d, 1'b0);
        step(1'b0, d, 1'b0);
    endtask

    task automatic take(output logic [WIDTH-1:0] d);
        for (int k = 0; k < 8 && !out_rdy; k++) step(si, din, 1'b0);
        d = dout;
        step(si, din, 1'b1);
        chk("R5 out_rdy low after shift_out high", int'(out_rdy), 0);
        step(si, din, 1'b0);
    endtask

    task automatic do_reset(input bit si_level);
        rst_n = 1'b0;
        step(si_level, 4'h9, 1'b0);
        step(si_level, 4'h9, 1'b0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog (all requirements): actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [WIDTH-1:0] w;
        model_edge();

        // R1: reset state
        do_reset(1'b0);
        chk("R1 in_rdy", int'(in_rdy), 1);
        chk("R1 out_rdy", int'(out_rdy), 0);
        chk("R1 data_out", int'(dout), 0);
        rst_n = 1'b1;
        step(1'b0, 4'h0, 1'b0);
        chk("R11 low at release in_rdy", int'(in_rdy), 1);

        // R7: one-clock fall-through latency
        step(1'b1, 4'hA, 1'b0);
        chk("R7 not yet presented", int'(out_rdy), 0);
        chk("R2 in_rdy low while shift_in high", int'(in_rdy), 0);
        step(1'b1, 4'hA, 1'b0);
        chk("R7 waits for shift_in low", int'(out_rdy), 0);
        step(1'b0, 4'hA, 1'b0);
        chk("R7 out_rdy", int'(out_rdy), 1);
        chk("R7 data_out", int'(dout), 'hA);
        take(w);
        chk("R3 word A", int'(w), 'hA);
        chk("R8 data_out held", int'(dout), 'hA);

        // R6: shift_out pulses while empty
        step(1'b0, 4'h0, 1'b1);
        step(1'b0, 4'h0, 1'b0);
        step(1'b0, 4'h0, 1'b0);
        chk("R6 out_rdy", int'(out_rdy), 0);
        chk("R6 data_out unchanged", int'(dout), 'hA);

        // R3: order with a mixed pattern
        for (int i = 0; i < 6; i++) put(4'((i * 5 + 3)));
        for (int i = 0; i < 6; i++) begin
            take(w);
            chk("R3 order", int'(w), (i * 5 + 3) % 16);
        end

        // R4: fill to capacity, extra pulse ignored
        for (int i = 0; i < DEPTH; i++) put(4'(i));
        chk("R4 in_rdy at full", int'(in_rdy), 0);
        put(4'hF);
        chk("R4 in_rdy still low", int'(in_rdy), 0);
        for (int i = 0; i < DEPTH; i++) begin
            take(w);
            chk("R3 drained word", int'(w), i % 16);
        end
        for (int k = 0; k < 4; k++) step(1'b0, 4'h0, 1'b0);
        chk("R4 extra word not stored", int'(out_rdy), 0);

        // R9: shift_out held high, one-clock out_rdy pulse
        step(1'b0, 4'h0, 1'b1);
        step(1'b1, 4'h6, 1'b1);
        step(1'b0, 4'h6, 1'b1);
        chk("R9 pulse high", int'(out_rdy), 1);
        chk("R9 data_out", int'(dout), 6);
        step(1'b0, 4'h6, 1'b1);
        chk("R9 pulse ends", int'(out_rdy), 0);
        step(1'b0, 4'h6, 1'b0);
        step(1'b0, 4'h6, 1'b0);
        chk("R8 emptied, data_out kept", int'(dout), 6);
        chk("R6 empty after removal", int'(out_rdy), 0);

        // R10: full with shift_in held high
        for (int i = 0; i < DEPTH; i++) put(4'(i + 1));
        step(1'b1, 4'hC, 1'b0);
        step(1'b1, 4'hC, 1'b0);
        chk("R10 in_rdy low while full", int'(in_rdy), 0);
        step(1'b1, 4'hC, 1'b1);
        step(1'b1, 4'hC, 1'b0);
        chk("R10 in_rdy pulse", int'(in_rdy), 1);
        step(1'b1, 4'hC, 1'b0);
        chk("R10 pulse ends after capture", int'(in_rdy), 0);
        step(1'b0, 4'hC, 1'b0);
        for (int i = 1; i < DEPTH; i++) begin
            take(w);
            chk("R10 earlier words", int'(w), (i + 1) % 16);
        end
        take(w);
        chk("R10 auto-loaded word last", int'(w), 'hC);

        // R11: shift_in high across release
        put(4'h3);
        do_reset(1'b1);
        chk("R1 data_out cleared", int'(dout), 0);
        rst_n = 1'b1;
        din = 4'h5;
        step(1'b1, 4'h5, 1'b0);
        chk("R11 in_rdy low after capture", int'(in_rdy), 0);
        step(1'b1, 4'h5, 1'b0);
        chk("R11 in_rdy stays low", int'(in_rdy), 0);
        step(1'b0, 4'h5, 1'b0);
        chk("R11 in_rdy back", int'(in_rdy), 1);
        chk("R11 word captured", int'(dout), 5);
        take(w);
        for (int k = 0; k < 3; k++) step(1'b0, 4'h0, 1'b0);
        chk("R11 single word only", int'(out_rdy), 0);

        // R11: shift_in dropped before release
        do_reset(1'b1);
        step(1'b0, 4'h7, 1'b0);
        rst_n = 1'b1;
        step(1'b0, 4'h7, 1'b0);
        step(1'b0, 4'h7, 1'b0);
        chk("R11 nothing captured", int'(out_rdy), 0);
        chk("R11 in_rdy high", int'(in_rdy), 1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule